// File: doc/BRIEF.md
# Serial Stuck-At Fault Grader

This block grades a set of test vectors against single stuck-at faults on a small combinational circuit that is built into it. After a start request it reads every vector from an external vector memory and applies it to the circuit with no fault present. The responses are kept in an internal response store. It then walks an external fault list. For each entry it forces one circuit line to a constant and replays the vectors in order, comparing each faulty response with the stored response for the same vector.

A fault is reported as caught at the first vector whose response differs, and the vectors that remain are not applied for that fault. A fault that survives every vector is reported as missed, and its list position is queued in a small result FIFO. When the list is exhausted, a one-cycle done pulse is raised. The count of caught faults and the number of listed faults are held beside it, so coverage is their ratio. Each vector application takes one clock, so the worst case is vector count times fault count steps plus a small per-fault overhead.

The built-in circuit has four inputs v[3:0] and seven fault sites. Sites 0 to 3 are the inputs v[0] to v[3]. Site 4 is the AND of sites 0 and 1, site 5 is the OR of sites 2 and 3, and site 6 is the XOR of sites 4 and 5. The response is {site 4, site 6}.

Top module: `fg_grader`

## Requirements
- R1: After reset, busy, done, rep_valid and det_count are 0, flt_total is 0 and und_empty is 1.
- R2: A start taken in idle (sampled at clock edge P0) latches vec_cnt and flt_cnt. The fault-free pass then occupies vec_cnt+1 cycles, and the first fault entry is fetched in the following cycle. The first report is therefore visible after edge P(vec_cnt+3+e), where e is that fault's effective vector count as defined in R4 and R5.
- R3: A fault entry is 4 bits: bits [3:1] select the site and bit 0 is the stuck value. Exactly that one line is forced while the entry is graded. Site value 7 injects nothing, so such an entry is always reported missed.
- R4: While a fault is graded, vector j (from 0) is compared with stored response j. On the first mismatch the fault is reported with rep_hit=1 and det_count increments. No further vector is applied: the report comes j+2 cycles after the previous report, so e=j.
- R5: A fault with no mismatch over all vectors is reported with rep_hit=0, vec_cnt+2 cycles after the previous report (e=vec_cnt).
- R6: Reports come as one-cycle rep_valid pulses in fault-list order, with rep_idx equal to the list position, exactly one per listed fault.
- R7: One cycle after the last report (or after the fetch cycle when flt_cnt is 0), done is high for exactly one cycle. det_count then equals the number of caught faults and flt_total equals flt_cnt, and busy is 0 in the next cycle.
- R8: Missed list positions are readable from the result FIFO in list order. und_idx shows the head while und_empty is 0, und_pop removes it, and a pop while empty is ignored. A new start clears the FIFO.
- R9: A start while busy (including the done cycle) is ignored: the run's counts, timing and results are unchanged.
- R10: vec_cnt=0 makes every fault missed; flt_cnt=0 finishes with no report and det_count=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a grading run (idle only) |
| vec_cnt | input | 5 | Number of vectors, 0..16 |
| flt_cnt | input | 5 | Number of fault entries, 0..16 |
| vec_addr | output | 4 | Vector memory read address |
| vec_data | input | 4 | Vector word at vec_addr, same cycle |
| flt_addr | output | 4 | Fault list read address |
| flt_data | input | 4 | Fault entry at flt_addr, same cycle |
| busy | output | 1 | Run in progress |
| rep_valid | output | 1 | Per-fault report strobe |
| rep_hit | output | 1 | Reported fault was caught |
| rep_idx | output | 4 | List position of reported fault |
| done | output | 1 | One-cycle end-of-run pulse |
| det_count | output | 5 | Faults caught in the run |
| flt_total | output | 5 | Faults listed in the run |
| und_pop | input | 1 | Remove FIFO head |
| und_empty | output | 1 | Result FIFO empty |
| und_idx | output | 4 | Missed fault position at FIFO head |

## Verification
The hardest behaviour to observe is the early stop: from the ports it shows only as the spacing between report pulses. The bench therefore predicts, from its own model of the circuit, the first failing vector of every fault and the exact cycle of every report and of done. It then checks each cycle against that schedule. The schedule is checked over a scrambled complete vector set, a short vector set that leaves faults missed, zero-length runs, and a run hit by a second start with different counts while busy.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int VEC_W     = 4;
    localparam int OUT_W     = 2;
    localparam int SITE_W    = 3;
    localparam int FAULT_W   = SITE_W + 1;
    localparam logic [SITE_W-1:0] SITE_NONE = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GOLD,
        ST_FETCH,
        ST_GRADE,
        ST_FIN
    } grade_state_e;
endpackage

// File: rtl/fg_cut.sv
module fg_cut
    import fg_pkg::*;
(
    input  logic [VEC_W-1:0]  vec,
    input  logic [SITE_W-1:0] site,
    input  logic              stuck,
    output logic [OUT_W-1:0]  resp
);
    logic [VEC_W-1:0] in_l;
    logic             and_l;
    logic             or_l;
    logic             xor_l;

    for (genvar i = 0; i < VEC_W; i++) begin : g_in
        assign in_l[i] = (site == SITE_W'(i)) ? stuck : vec[i];
    end

    assign and_l = (site == SITE_W'(4)) ? stuck : (in_l[0] & in_l[1]);
    assign or_l  = (site == SITE_W'(5)) ? stuck : (in_l[2] | in_l[3]);
    assign xor_l = (site == SITE_W'(6)) ? stuck : (and_l ^ or_l);

    assign resp = {and_l, xor_l};
endmodule

// File: rtl/fg_golden.sv
module fg_golden
    import fg_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [OUT_W-1:0] wdata,
    output logic [OUT_W-1:0] rdata
);
    logic [OUT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/fg_undq.sv
module fg_undq #(
    parameter int DEPTH = 16,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_regs_t;

    q_regs_t       r_q, r_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    assign empty   = (r_q.cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (r_q.cnt != CW'(DEPTH));
    assign dout    = mem_q[r_q.rp];

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else begin
            if (do_push) r_d.wp = r_q.wp + 1'b1;
            if (do_pop)  r_d.rp = r_q.rp + 1'b1;
            r_d.cnt = r_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[r_q.wp] <= din;
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (r_q.cnt != CW'(DEPTH))); // R8
    AST_FIFO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty); // R8
endmodule

// File: rtl/fg_grader.sv
module fg_grader
    import fg_pkg::*;
#(
    parameter int MAX_VEC = 16,
    parameter int MAX_FLT = 16,
    localparam int VA     = $clog2(MAX_VEC),
    localparam int FA     = $clog2(MAX_FLT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VA:0]        vec_cnt,
    input  logic [FA:0]        flt_cnt,
    output logic [VA-1:0]      vec_addr,
    input  logic [VEC_W-1:0]   vec_data,
    output logic [FA-1:0]      flt_addr,
    input  logic [FAULT_W-1:0] flt_data,
    output logic               busy,
    output logic               rep_valid,
    output logic               rep_hit,
    output logic [FA-1:0]      rep_idx,
    output logic               done,
    output logic [FA:0]        det_count,
    output logic [FA:0]        flt_total,
    input  logic               und_pop,
    output logic               und_empty,
    output logic [FA-1:0]      und_idx
);
    typedef struct packed {
        grade_state_e       st;
        logic [VA:0]        nv;
        logic [FA:0]        nf;
        logic [VA:0]        vi;
        logic [FA:0]        fi;
        logic [FAULT_W-1:0] fault;
        logic [FA:0]        det;
        logic               rep_v;
        logic               rep_h;
        logic [FA-1:0]      rep_i;
    } ctl_regs_t;

    ctl_regs_t         r_q, r_d;
    logic [SITE_W-1:0] inj_site;
    logic              inj_stuck;
    logic [OUT_W-1:0]  cut_resp;
    logic [OUT_W-1:0]  gold_resp;
    logic              gold_we;
    logic              q_push;
    logic              q_clr;

    fg_cut u_cut (
        .vec   (vec_data),
        .site  (inj_site),
        .stuck (inj_stuck),
        .resp  (cut_resp)
    );

    fg_golden #(.DEPTH(MAX_VEC)) u_gold (
        .clk   (clk),
        .we    (gold_we),
        .addr  (r_q.vi[VA-1:0]),
        .wdata (cut_resp),
        .rdata (gold_resp)
    );

    fg_undq #(.DEPTH(MAX_FLT), .DW(FA)) u_undq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_clr),
        .push  (q_push),
        .din   (r_q.fi[FA-1:0]),
        .pop   (und_pop),
        .dout  (und_idx),
        .empty (und_empty)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rep_v = 1'b0;
        inj_site  = SITE_NONE;
        inj_stuck = 1'b0;
        gold_we   = 1'b0;
        q_push    = 1'b0;
        q_clr     = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.nv  = vec_cnt;
                    r_d.nf  = flt_cnt;
                    r_d.vi  = '0;
                    r_d.fi  = '0;
                    r_d.det = '0;
                    r_d.st  = ST_GOLD;
                    q_clr   = 1'b1;
                end
            end
            ST_GOLD: begin
                if (r_q.vi == r_q.nv) begin
                    r_d.st = ST_FETCH;
                end else begin
                    gold_we = 1'b1;
                    r_d.vi  = r_q.vi + 1'b1;
                end
            end
            ST_FETCH: begin
                if (r_q.fi == r_q.nf) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.fault = flt_data;
                    r_d.vi    = '0;
                    r_d.st    = ST_GRADE;
                end
            end
            ST_GRADE: begin
                inj_site  = r_q.fault[FAULT_W-1:1];
                inj_stuck = r_q.fault[0];
                if (r_q.vi == r_q.nv) begin
                    r_d.rep_v = 1'b1;
                    r_d.rep_h = 1'b0;
                    r_d.rep_i = r_q.fi[FA-1:0];
                    q_push    = 1'b1;
                    r_d.fi    = r_q.fi + 1'b1;
                    r_d.st    = ST_FETCH;
                end else if (cut_resp != gold_resp) begin
                    r_d.rep_v = 1'b1;
                    r_d.rep_h = 1'b1;
                    r_d.rep_i = r_q.fi[FA-1:0];
                    r_d.det   = r_q.det + 1'b1;
                    r_d.fi    = r_q.fi + 1'b1;
                    r_d.st    = ST_FETCH;
                end else begin
                    r_d.vi = r_q.vi + 1'b1;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign vec_addr  = r_q.vi[VA-1:0];
    assign flt_addr  = r_q.fi[FA-1:0];
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FIN);
    assign rep_valid = r_q.rep_v;
    assign rep_hit   = r_q.rep_h;
    assign rep_idx   = r_q.rep_i;
    assign det_count = r_q.det;
    assign flt_total = r_q.nf;

    AST_REPORT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> (busy && !done)); // R6
    AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> !rep_valid); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (det_count <= flt_total)); // R7
    AST_HIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_hit) |-> (det_count == $past(det_count) + 1'b1)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(flt_total)); // R9
    AST_MISS_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_hit) |-> !und_empty); // R8
endmodule

// File: tb/fg_grader_test.sv
module fg_grader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] vec_cnt = '0;
    logic [4:0] flt_cnt = '0;
    logic [3:0] vec_addr;
    logic [3:0] vec_data;
    logic [3:0] flt_addr;
    logic [3:0] flt_data;
    logic       busy, rep_valid, rep_hit, done, und_empty;
    logic [3:0] rep_idx, und_idx;
    logic [4:0] det_count, flt_total;
    logic       und_pop = 1'b0;

    logic [3:0] vmem [16];
    logic [3:0] fmem [16];

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign vec_data = vmem[vec_addr];
    assign flt_data = fmem[flt_addr];

    fg_grader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_cnt(vec_cnt), .flt_cnt(flt_cnt),
        .vec_addr(vec_addr), .vec_data(vec_data), .flt_addr(flt_addr), .flt_data(flt_data),
        .busy(busy), .rep_valid(rep_valid), .rep_hit(rep_hit), .rep_idx(rep_idx),
        .done(done), .det_count(det_count), .flt_total(flt_total),
        .und_pop(und_pop), .und_empty(und_empty), .und_idx(und_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [3:0] v, input logic [3:0] f);
        logic [6:0] l;
        logic [2:0] s;
        s = f[3:1];
        for (int i = 0; i < 4; i++) l[i] = (s == 3'(i)) ? f[0] : v[i];
        l[4] = (s == 3'd4) ? f[0] : (l[0] & l[1]);
        l[5] = (s == 3'd5) ? f[0] : (l[2] | l[3]);
        l[6] = (s == 3'd6) ? f[0] : (l[4] ^ l[5]);
        return {l[4], l[6]};
    endfunction

    task automatic drain(input int ulist[16], input int nu);
        for (int u = 0; u < nu; u++) begin
            chk(und_empty === 1'b0, "R8", und_empty, 0);
            chk(und_idx === 4'(ulist[u]), "R8", und_idx, ulist[u]);
            und_pop = 1'b1;
            @(negedge clk);
            und_pop = 1'b0;
        end
        chk(und_empty === 1'b1, "R8", und_empty, 1);
        und_pop = 1'b1;
        @(negedge clk);
        und_pop = 1'b0;
        @(negedge clk);
        chk(und_empty === 1'b1, "R8", und_empty, 1);
    endtask

    task automatic do_run(input int nv, input int nf, input bit poke);
        logic [1:0] gold [16];
        int times [16];
        bit hits [16];
        int ulist [16];
        int nu = 0;
        int ndet = 0;
        int r = 0;
        int t;
        int first;
        int exp_done;
        bit exp_rep;
        string tag;
        for (int j = 0; j < nv; j++) gold[j] = model(vmem[j], 4'b1110);
        t = nv + 1;
        for (int k = 0; k < nf; k++) begin
            first = nv;
            for (int j = nv - 1; j >= 0; j--)
                if (model(vmem[j], fmem[k]) != gold[j]) first = j;
            hits[k] = (first < nv);
            times[k] = t + first + 2;
            t = times[k];
            if (hits[k]) ndet++;
            else begin ulist[nu] = k; nu++; end
        end
        exp_done = t + 1;

        @(negedge clk);
        vec_cnt = 5'(nv);
        flt_cnt = 5'(nf);
        start = 1'b1;
        for (int cyc = 0; cyc <= exp_done + 1; cyc++) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (poke && cyc == 2) begin
                start = 1'b1; vec_cnt = 5'd1; flt_cnt = 5'd1;
            end
            if (poke && cyc == 3) begin
                start = 1'b0; vec_cnt = 5'(nv); flt_cnt = 5'(nf);
            end
            exp_rep = (r < nf) && (cyc == times[r]);
            if (poke) tag = "R9";
            else if (r == 0) tag = "R2";
            else if (r < nf && !hits[r]) tag = "R5";
            else tag = "R4";
            chk(rep_valid === exp_rep, tag, rep_valid, exp_rep);
            if (exp_rep && rep_valid === 1'b1) begin
                chk(rep_idx === 4'(r), "R6", rep_idx, r);
                if (fmem[r][3:1] == 3'b111) tag = "R3";
                else if (hits[r]) tag = "R4";
                else tag = "R5";
                chk(rep_hit === hits[r], tag, rep_hit, hits[r]);
            end
            if (exp_rep) r++;
            chk(done === (cyc == exp_done), "R7", done, cyc == exp_done);
            if (cyc == exp_done) begin
                chk(det_count === 5'(ndet), nv == 0 || nf == 0 ? "R10" : "R7", det_count, ndet);
                chk(flt_total === 5'(nf), poke ? "R9" : "R7", flt_total, nf);
            end
        end
        chk(busy === 1'b0, "R7", busy, 0);
        drain(ulist, nu);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R1", busy, 0);
        chk(done === 1'b0, "R1", done, 0);
        chk(rep_valid === 1'b0, "R1", rep_valid, 0);
        chk(det_count === 5'd0, "R1", det_count, 0);
        chk(flt_total === 5'd0, "R1", flt_total, 0);
        chk(und_empty === 1'b1, "R1", und_empty, 1);
    endtask

    task automatic t_full;      do_run(16, 16, 1'b0); endtask
    task automatic t_short;     do_run(3, 16, 1'b0);  endtask
    task automatic t_novec;     do_run(0, 5, 1'b0);   endtask
    task automatic t_nofault;   do_run(4, 0, 1'b0);   endtask
    task automatic t_busystart; do_run(5, 6, 1'b1);   endtask

    task automatic t_reorder;
        for (int k = 0; k < 16; k++) fmem[k] = 4'(15 - k);
        do_run(6, 10, 1'b0);
        for (int k = 0; k < 16; k++) fmem[k] = 4'(k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            vmem[i] = 4'((i * 7 + 3) & 15);
            fmem[i] = 4'(i);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_short();
        t_novec();
        t_nofault();
        t_busystart();
        t_reorder();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule